// File: doc/BRIEF.md
# Slave Serial Configuration Sequencer

This block loads a configuration image into a programmable logic device that is set up to receive its configuration one bit at a time, with the clock driven from outside. An upstream source presents image bytes on a valid/ready interface and flags the final byte. The sequencer sends each byte out on a single data line, most significant bit first. A configuration clock pulses once per payload bit and does nothing else. Any protocol overhead of the storage device that feeds the upstream source never reaches this clock.

The sequencer also runs the bring-up procedure around the image transfer. After reset it waits a programmable settle interval. It then waits for the device's ready line (INIT) to read high and streams the image. After the last byte it checks that both the done line and the ready line are high. If either is low, it pulls the open-drain PROGRAM line low for a programmable number of cycles and starts the whole sequence again. After a successful load it idles until PROGRAM is pulled low from outside, for example by a push-button, and then starts a fresh load. A two-bit status output reports the current condition.

The image itself begins with the synchronisation words FFFFFFFF and AA995566 and is smaller than 64 KB. The sequencer does not interpret the image. It only serialises it.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, status reads 0 (idle), cfg_clk is low, prog_pull is low and in_ready stays low for SETTLE_CYCLES clock cycles, even while INIT reads high. When the interval ends and INIT is high, in_ready rises.
- R2: Once the settle interval has elapsed, no byte is accepted (in_ready stays low) for as long as INIT reads low.
- R3: Each accepted byte appears on cfg_dout most significant bit first, with exactly one cfg_clk rising edge per bit and eight per byte. cfg_dout does not change while cfg_clk is high.
- R4: cfg_clk stays low between bytes when no byte is offered, and whenever status is not 1.
- R5: Each cfg_clk high phase lasts exactly HALF_PERIOD clock cycles.
- R6: After the byte flagged by in_last has been shifted out and CHECK_CYCLES have passed, DONE and INIT both high give status 2 (done), with prog_pull low.
- R7: If DONE or INIT is low at that check, status becomes 3 (failed). prog_pull is then high for exactly PULSE_CYCLES consecutive cycles. Once PROGRAM reads high again, the sequence restarts from the settle interval, and a later successful load reaches status 2.
- R8: While status is 2, PROGRAM read low from outside sets status to 0. Once PROGRAM is released, the sequence restarts from the settle interval and loads again.
- R9: Status encoding: 0 idle (settling or waiting for INIT), 1 loading, 2 done, 3 failed. Failed holds until the next load begins.
- R10: in_ready is high only while status is 1 and no byte is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Image byte from upstream |
| in_valid | input | 1 | in_data holds a byte |
| in_last | input | 1 | Current byte is the final byte of the image |
| in_ready | output | 1 | Byte is accepted when in_valid and in_ready are both high |
| cfg_clk | output | 1 | Configuration clock to the device |
| cfg_dout | output | 1 | Configuration data bit to the device |
| init_in | input | 1 | Level of the open-drain INIT line (high = ready, low = error) |
| done_in | input | 1 | Level of the open-drain DONE line |
| prog_in | input | 1 | Level of the open-drain PROGRAM line |
| prog_pull | output | 1 | When high, PROGRAM is driven low |
| status | output | 2 | 0 idle, 1 loading, 2 done, 3 failed |

## Verification
The checker tests several rules on every cycle:
- cfg_dout holds steady while cfg_clk is high.
- cfg_clk is quiet outside loading.
- in_ready is raised only when loading and with the serializer empty.
- PROGRAM is pulled only in the failed state.

Bit order, the one-pulse-per-bit count, the clock high-phase width, the exact PROGRAM pulse length, the settle delay and the restart paths depend on sequences over time. Only the bench scenarios show these: success, an external reconfigure request, and an induced failure followed by a retry.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

  typedef enum logic [1:0] {
    STAT_IDLE    = 2'd0,
    STAT_LOADING = 2'd1,
    STAT_DONE    = 2'd2,
    STAT_FAILED  = 2'd3
  } cfg_status_e;

  typedef enum logic [2:0] {
    PH_SETTLE,
    PH_WAIT_INIT,
    PH_LOAD,
    PH_DRAIN,
    PH_CHECK,
    PH_PULSE,
    PH_CONFIGURED,
    PH_RELEASE
  } cfg_phase_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer #(
  parameter int WIDTH   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] value,
  output logic             expired
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= WIDTH'(RST_VAL);
    else if (start)         cnt_q <= value;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int HALF_PERIOD = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] byte_in,
  output logic       ready,
  output logic       cclk,
  output logic       dout
);
  localparam int HW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

  logic          busy_q;
  logic [7:0]    sreg_q;
  logic [2:0]    bits_q;
  logic [HW-1:0] half_q;
  logic          cclk_q;
  logic          dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sreg_q <= '0;
      bits_q <= '0;
      half_q <= '0;
      cclk_q <= 1'b0;
      dout_q <= 1'b0;
    end else if (!busy_q) begin
      if (load) begin
        busy_q <= 1'b1;
        sreg_q <= byte_in;
        dout_q <= byte_in[7];
        bits_q <= 3'd7;
        half_q <= HW'(HALF_PERIOD - 1);
      end
    end else if (half_q != '0) begin
      half_q <= half_q - 1'b1;
    end else begin
      half_q <= HW'(HALF_PERIOD - 1);
      if (!cclk_q) begin
        cclk_q <= 1'b1;
      end else begin
        cclk_q <= 1'b0;
        if (bits_q == 3'd0) begin
          busy_q <= 1'b0;
        end else begin
          bits_q <= bits_q - 1'b1;
          sreg_q <= {sreg_q[6:0], 1'b0};
          dout_q <= sreg_q[6];
        end
      end
    end
  end

  assign ready = !busy_q;
  assign cclk  = cclk_q;
  assign dout  = dout_q;
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import serial_cfg_pkg::*;
#(
  parameter int SETTLE_CYCLES = 12_500_000,
  parameter int PULSE_CYCLES  = 125,
  parameter int CHECK_CYCLES  = 64,
  parameter int HALF_PERIOD   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic       cfg_clk,
  output logic       cfg_dout,
  input  logic       init_in,
  input  logic       done_in,
  input  logic       prog_in,
  output logic       prog_pull,
  output logic [1:0] status
);
  localparam int MAX_A = (SETTLE_CYCLES > PULSE_CYCLES) ? SETTLE_CYCLES : PULSE_CYCLES;
  localparam int MAX_T = (MAX_A > CHECK_CYCLES) ? MAX_A : CHECK_CYCLES;
  localparam int CNT_W = $clog2(MAX_T + 1);

  cfg_phase_e  phase_q, phase_d;
  cfg_status_e stat_q;
  logic        pull_q;
  logic        tmr_start, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic        sh_ready, sh_load;
  logic [2:0]  lines_s;
  logic        init_s, done_s, prog_s;

  cfg_sync #(.WIDTH(3), .STAGES(2)) i_sync (
    .clk(clk), .rst(rst),
    .d_in({prog_in, done_in, init_in}),
    .d_out(lines_s)
  );
  assign init_s = lines_s[0];
  assign done_s = lines_s[1];
  assign prog_s = lines_s[2];

  cfg_timer #(.WIDTH(CNT_W), .RST_VAL(SETTLE_CYCLES - 1)) i_timer (
    .clk(clk), .rst(rst), .start(tmr_start), .value(tmr_val), .expired(tmr_zero)
  );

  assign in_ready = (phase_q == PH_LOAD) && sh_ready;
  assign sh_load  = in_ready && in_valid;

  cfg_shifter #(.HALF_PERIOD(HALF_PERIOD)) i_shift (
    .clk(clk), .rst(rst), .load(sh_load), .byte_in(in_data),
    .ready(sh_ready), .cclk(cfg_clk), .dout(cfg_dout)
  );

  always_comb begin
    phase_d   = phase_q;
    tmr_start = 1'b0;
    tmr_val   = '0;
    case (phase_q)
      PH_SETTLE:    if (tmr_zero) phase_d = PH_WAIT_INIT;
      PH_WAIT_INIT: if (init_s) phase_d = PH_LOAD;
      PH_LOAD:      if (sh_load && in_last) phase_d = PH_DRAIN;
      PH_DRAIN: begin
        if (sh_ready) begin
          phase_d   = PH_CHECK;
          tmr_start = 1'b1;
          tmr_val   = CNT_W'(CHECK_CYCLES - 1);
        end
      end
      PH_CHECK: begin
        if (tmr_zero) begin
          if (done_s && init_s) begin
            phase_d = PH_CONFIGURED;
          end else begin
            phase_d   = PH_PULSE;
            tmr_start = 1'b1;
            tmr_val   = CNT_W'(PULSE_CYCLES - 1);
          end
        end
      end
      PH_PULSE:      if (tmr_zero) phase_d = PH_RELEASE;
      PH_CONFIGURED: if (!prog_s) phase_d = PH_RELEASE;
      PH_RELEASE: begin
        if (prog_s) begin
          phase_d   = PH_SETTLE;
          tmr_start = 1'b1;
          tmr_val   = CNT_W'(SETTLE_CYCLES - 1);
        end
      end
      default: phase_d = PH_SETTLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_SETTLE;
      stat_q  <= STAT_IDLE;
      pull_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pull_q  <= (phase_d == PH_PULSE);
      if (phase_q == PH_WAIT_INIT && phase_d == PH_LOAD)    stat_q <= STAT_LOADING;
      if (phase_q == PH_CHECK && phase_d == PH_CONFIGURED)  stat_q <= STAT_DONE;
      if (phase_q == PH_CHECK && phase_d == PH_PULSE)       stat_q <= STAT_FAILED;
      if (phase_q == PH_CONFIGURED && phase_d == PH_RELEASE) stat_q <= STAT_IDLE;
    end
  end

  assign prog_pull = pull_q;
  assign status    = stat_q;
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       cfg_clk,
  input logic       cfg_dout,
  input logic       prog_pull,
  input logic [1:0] status
);
  // R3
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_clk |-> $stable(cfg_dout));

  // R4
  clk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_clk |-> (status == 2'd1));

  // R10
  ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (status == 2'd1) && !cfg_clk);

  // R7
  pull_fail_chk: assert property (@(posedge clk) disable iff (rst)
    prog_pull |-> (status == 2'd3));

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (status == 2'd2) |-> !prog_pull && !in_ready && !cfg_clk);
endmodule

bind serial_cfg_loader serial_cfg_loader_chk i_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .cfg_clk(cfg_clk),
  .cfg_dout(cfg_dout), .prog_pull(prog_pull), .status(status)
);

// File: tb/test_serial_cfg_loader.sv
`timescale 1ns/1ps
module test_serial_cfg_loader;
  localparam int SETTLE = 40;
  localparam int PULSE  = 10;
  localparam int CHECKW = 8;
  localparam int HALF   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic in_ready, cfg_clk, cfg_dout, prog_pull;
  logic init_line = 1'b1, done_line = 1'b0, ext_press = 1'b0;
  logic prog_line;
  logic [1:0] status;

  int errors = 0;
  int checks = 0;
  bit exp_q[$];
  int last_pulse = 0;

  assign prog_line = !(prog_pull || ext_press);

  always #4 clk = !clk;

  serial_cfg_loader #(
    .SETTLE_CYCLES(SETTLE), .PULSE_CYCLES(PULSE),
    .CHECK_CYCLES(CHECKW), .HALF_PERIOD(HALF)
  ) i_serial_cfg_loader (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .cfg_clk(cfg_clk),
    .cfg_dout(cfg_dout), .init_in(init_line), .done_in(done_line),
    .prog_in(prog_line), .prog_pull(prog_pull), .status(status)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: scoreboard for serial bits, clock phase width, PROGRAM pulse width
  logic prev_cclk = 1'b0;
  int   high_run = 0;
  int   pull_run = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (cfg_clk && !prev_cclk) begin
        high_run = 1;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected cfg_clk pulse", 1, 0);
        end else begin
          bit e;
          e = exp_q.pop_front();
          chk(cfg_dout == e, "R3 bit value", cfg_dout, e);
        end
      end else if (cfg_clk) begin
        high_run++;
      end
      if (!cfg_clk && prev_cclk)
        chk(high_run == HALF, "R5 high phase width", high_run, HALF);
      if (prog_pull) pull_run++;
      else if (pull_run != 0) begin
        last_pulse = pull_run;
        pull_run = 0;
      end
    end
    prev_cclk = cfg_clk;
  end

  // watchdog
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "watchdog expired", cyc, 100000);
      finish_run();
    end
  end

  task automatic wait_ready(input string tag, input int max);
    int n = 0;
    while (!in_ready && n < max) begin
      @(negedge clk);
      n++;
    end
    chk(in_ready, tag, in_ready, 1);
  endtask

  task automatic wait_status(input int exp, input string tag, input int max);
    int n = 0;
    while (status != exp && n < max) begin
      @(negedge clk);
      n++;
    end
    chk(status == exp, tag, status, exp);
  endtask

  task automatic send_image(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      case (i)
        0, 1, 2, 3: b = 8'hFF;
        4: b = 8'hAA;
        5: b = 8'h99;
        6: b = 8'h55;
        7: b = 8'h66;
        default: b = 8'((i * 37 + 5) & 255);
      endcase
      for (int k = 7; k >= 0; k--) exp_q.push_back(b[k]);
      in_data  = b;
      in_last  = (i == n - 1);
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      // R10: serializer busy right after accept
      if (i == 0) chk(!in_ready, "R10 ready low while shifting", in_ready, 0);
      if (i == 3 || i == 8) begin
        if (i < n - 1) begin
          while (!in_ready) @(negedge clk);
          for (int g = 0; g < 4; g++) begin
            @(negedge clk);
            // R4: idle clock in an inter-byte gap
            chk(!cfg_clk, "R4 cfg_clk low in gap", cfg_clk, 0);
          end
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 / R9 reset state
    chk(status == 2'd0, "R9 idle after reset", status, 0);
    chk(!cfg_clk, "R1 cfg_clk low after reset", cfg_clk, 0);
    chk(!prog_pull, "R1 prog released after reset", prog_pull, 0);
    repeat (20) @(negedge clk);
    chk(!in_ready, "R1 no ready during settle", in_ready, 0);
    wait_ready("R1 ready after settle", 200);

    // first load succeeds
    done_line = 1'b1;
    send_image(14);
    wait_status(2, "R6 done status", 400);
    chk(!prog_pull, "R6 prog not pulled", prog_pull, 0);
    chk(exp_q.size() == 0, "R3 all bits clocked", exp_q.size(), 0);

    // external reconfigure request
    ext_press = 1'b1;
    init_line = 1'b0;
    done_line = 1'b0;
    repeat (6) @(negedge clk);
    chk(status == 2'd0, "R8 idle after external PROGRAM", status, 0);
    ext_press = 1'b0;
    repeat (120) @(negedge clk);
    chk(!in_ready, "R2 no ready while INIT low", in_ready, 0);
    chk(status == 2'd0, "R2 still idle while INIT low", status, 0);
    init_line = 1'b1;
    wait_ready("R8 reload after release", 50);

    // second load fails (DONE stays low)
    send_image(10);
    wait_status(3, "R7 failed status", 400);
    while (prog_pull || last_pulse == 0) @(negedge clk);
    chk(last_pulse == PULSE, "R7 PROGRAM pulse width", last_pulse, PULSE);
    repeat (10) @(negedge clk);
    chk(!in_ready, "R7 settle before retry", in_ready, 0);
    chk(status == 2'd3, "R9 failed holds until reload", status, 3);
    wait_ready("R7 retry reaches loading", 200);
    chk(status == 2'd1, "R9 loading status", status, 1);

    // retry succeeds
    done_line = 1'b1;
    send_image(9);
    wait_status(2, "R7 retry done", 400);
    chk(exp_q.size() == 0, "R3 retry bits clocked", exp_q.size(), 0);
    finish_run();
  end
endmodule